// File: doc/BRIEF.md
# IOMMU Translation Window Checker

This block is the first stage of an IO address translation unit. Each incoming 32-bit IO address is tested against a configurable translated window. If the address is outside the window, the access is inhibited. If it is inside, the address is split into two parts: a right-aligned virtual page number that can index a page table directly, and a page offset that passes through untranslated. Three plain control pins set the behaviour:

- a range-size field. The window is 16 MiB times two to the power of this field.
- a window-base mask. This places the window whenever it is smaller than the full 4 GiB space.
- a page-size setting. Settings 0 to 3 select 4, 8, 16 or 32 KiB pages.

Addresses enter on a valid/ready stream, and results leave on a second valid/ready stream through one output register. An address is accepted in a cycle where `in_valid` and `in_ready` are both high. The control pins are sampled in that same cycle. The result appears on the next cycle and stays unchanged until `out_ready` takes it. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a downstream stall pushes back on the input immediately. While `out_ready` stays high, one address can pass every cycle.

Top module: `iowin_check`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all output fields hold their values.
- R3: When the clamped range size r is below 8, the address bits 31 down to 24+r are compared with the same bits of `cfg_base`. Any difference sets `out_inhibit`. For example, with r=2 the compare covers bits 31:26.
- R4: A range size of 8 covers the whole 4 GiB space and never inhibits. Any value above 8 behaves exactly like 8.
- R5: For a non-inhibited access, `out_offset` holds address bits [11+p:0] and is zero above them, where p is `cfg_pgsz` (0 gives 4 KiB pages, 3 gives 32 KiB pages).
- R6: For a non-inhibited access, `out_vpn` holds address bits [23+r:12+p] right-aligned (shifted down by 12+p) and is zero above them.
- R7: For an inhibited access, `out_inhibit` is 1 and both `out_vpn` and `out_offset` are zero, so no translation request is formed.
- R8: An address accepted in cycle n gives `out_valid` high in cycle n+1. The result uses the control pin values from cycle n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_range | input | 4 | Window size exponent (16 MiB << value, clamped to 8) |
| cfg_base | input | 32 | Window base mask for the upper address bits |
| cfg_pgsz | input | 2 | Page size setting: 4 KiB << value |
| in_valid | input | 1 | Incoming address valid |
| in_ready | output | 1 | Stage can accept an address |
| in_addr | input | 32 | Incoming IO address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_inhibit | output | 1 | Address outside the translated window |
| out_vpn | output | 20 | Right-aligned virtual page number |
| out_offset | output | 15 | Untranslated page offset |

## Verification
The bench targets the edges of the window:

- Addresses that differ from the base only in the lowest compared bit must be inhibited. A design with an off-by-one compare boundary would pass them instead.
- Addresses that differ only in the highest window bit must pass. An off-by-one boundary in the other direction would inhibit them.
- Range values above 8 must behave exactly like 8. A design that does not clamp them would inhibit these addresses or cut the page number short.
- Every page-size setting is tested with both range extremes. A wrong shift or mask would move a bit between the offset and the page number, or leave stale high bits in either.
- Random stalls on `out_ready` check that a held result never changes and that `in_ready` drops at once when the downstream stalls.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // Defaults shared by the stage and its bench.
  localparam int IOWIN_ADDR_W     = 32;
  localparam int IOWIN_BASE_SHIFT = 24;  // 16 MiB minimum window
  localparam int IOWIN_PAGE_SHIFT = 12;  // 4 KiB minimum page
  localparam int IOWIN_RANGE_W    = 4;
  localparam int IOWIN_PGSZ_W     = 2;
endpackage

// File: rtl/iowin_range_match.sv
module iowin_range_match #(
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 24,
  parameter int RANGE_W    = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ADDR_W-1:0]  base,
  input  logic [RANGE_W-1:0] r_eff,
  output logic               outside
);
  localparam int NCMP = ADDR_W - BASE_SHIFT;

  logic [NCMP-1:0] diff;

  // Bit BASE_SHIFT+k is part of the compare only when it lies above the window.
  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    logic above;
    assign above   = (int'(r_eff) <= k);
    assign diff[k] = above & (addr[BASE_SHIFT+k] ^ base[BASE_SHIFT+k]);
  end

  assign outside = |diff;
endmodule

// File: rtl/iowin_addr_split.sv
module iowin_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int RANGE_W    = 4,
  parameter int PGSZ_W     = 2
) (
  input  logic [ADDR_W-1:0]                        addr,
  input  logic [RANGE_W-1:0]                       r_eff,
  input  logic [PGSZ_W-1:0]                        pgsz,
  output logic [ADDR_W-PAGE_SHIFT-1:0]             vpn,
  output logic [PAGE_SHIFT+(1<<PGSZ_W)-2:0]        ofs
);
  localparam int VPN_W = ADDR_W - PAGE_SHIFT;
  localparam int OFS_W = PAGE_SHIFT + (1 << PGSZ_W) - 1;

  logic [ADDR_W-1:0] shifted;
  int                ofs_bits;
  int                vpn_bits;

  assign ofs_bits = PAGE_SHIFT + int'(pgsz);
  assign vpn_bits = BASE_SHIFT - PAGE_SHIFT + int'(r_eff) - int'(pgsz);
  assign shifted  = addr >> ofs_bits;

  for (genvar i = 0; i < OFS_W; i++) begin : g_ofs
    assign ofs[i] = addr[i] & (i < ofs_bits);
  end

  for (genvar j = 0; j < VPN_W; j++) begin : g_vpn
    assign vpn[j] = shifted[j] & (j < vpn_bits);
  end
endmodule

// File: rtl/iowin_out_reg.sv
module iowin_out_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/iowin_check.sv
module iowin_check
  import iowin_pkg::*;
#(
  parameter int ADDR_W     = IOWIN_ADDR_W,
  parameter int BASE_SHIFT = IOWIN_BASE_SHIFT,
  parameter int PAGE_SHIFT = IOWIN_PAGE_SHIFT,
  parameter int RANGE_W    = IOWIN_RANGE_W,
  parameter int PGSZ_W     = IOWIN_PGSZ_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [RANGE_W-1:0]                   cfg_range,
  input  logic [ADDR_W-1:0]                    cfg_base,
  input  logic [PGSZ_W-1:0]                    cfg_pgsz,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [ADDR_W-1:0]                    in_addr,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic                                 out_inhibit,
  output logic [ADDR_W-PAGE_SHIFT-1:0]         out_vpn,
  output logic [PAGE_SHIFT+(1<<PGSZ_W)-2:0]    out_offset
);
  localparam int RANGE_MAX = ADDR_W - BASE_SHIFT;
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT;
  localparam int OFS_W     = PAGE_SHIFT + (1 << PGSZ_W) - 1;
  localparam int PAY_W     = 1 + VPN_W + OFS_W;

  logic [RANGE_W-1:0] r_eff;
  logic               outside;
  logic [VPN_W-1:0]   vpn_c;
  logic [OFS_W-1:0]   ofs_c;
  logic [PAY_W-1:0]   pay_in;
  logic [PAY_W-1:0]   pay_out;

  // Range sizes beyond the full address space are treated as the full space.
  assign r_eff = (int'(cfg_range) > RANGE_MAX) ? RANGE_W'(RANGE_MAX) : cfg_range;

  iowin_range_match #(
    .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT), .RANGE_W(RANGE_W)
  ) u_match (
    .addr(in_addr), .base(cfg_base), .r_eff(r_eff), .outside(outside)
  );

  iowin_addr_split #(
    .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
    .RANGE_W(RANGE_W), .PGSZ_W(PGSZ_W)
  ) u_split (
    .addr(in_addr), .r_eff(r_eff), .pgsz(cfg_pgsz), .vpn(vpn_c), .ofs(ofs_c)
  );

  // An inhibited access carries no page number or offset.
  assign pay_in = outside ? {1'b1, {(VPN_W+OFS_W){1'b0}}} : {1'b0, vpn_c, ofs_c};

  iowin_out_reg #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign out_inhibit = pay_out[PAY_W-1];
  assign out_vpn     = pay_out[PAY_W-2 -: VPN_W];
  assign out_offset  = pay_out[OFS_W-1:0];

  a_r3_outside_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (int'(r_eff) < RANGE_MAX) &&
    ((in_addr >> (BASE_SHIFT + int'(r_eff))) != (cfg_base >> (BASE_SHIFT + int'(r_eff))))
    |=> out_inhibit);

  a_r4_full_never_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (int'(cfg_range) >= RANGE_MAX) |=> !out_inhibit);

  a_r5_offset_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !outside && (cfg_pgsz == '0)
    |=> out_offset == OFS_W'($past(in_addr) & ((ADDR_W'(1) << PAGE_SHIFT) - 1)));

  a_r7_inhibit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inhibit |-> (out_vpn == '0) && (out_offset == '0));
endmodule

// File: tb/iowin_check_bench.sv
`timescale 1ns/1ps
module iowin_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_range = '0;
  logic [31:0] cfg_base = '0;
  logic [1:0]  cfg_pgsz = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_inhibit;
  logic [19:0] out_vpn;
  logic [14:0] out_offset;

  int tests = 0;
  int fails = 0;

  // Reference model state
  bit          m_valid = 0;
  bit          m_inh = 0;
  logic [31:0] m_vpn = '0;
  logic [31:0] m_ofs = '0;

  always #2.5 clk = ~clk;

  iowin_check u_iowin_check (
    .clk(clk), .rst_n(rst_n), .cfg_range(cfg_range), .cfg_base(cfg_base),
    .cfg_pgsz(cfg_pgsz), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_inhibit(out_inhibit), .out_vpn(out_vpn), .out_offset(out_offset)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One clock: drive at the falling edge, compare after the next falling edge.
  task automatic step(bit v, logic [31:0] a, bit rdy, logic [3:0] rg, logic [31:0] bs, logic [1:0] pg);
    int r;
    int p;
    bit acc;
    bit n_inh;
    logic [31:0] n_vpn;
    logic [31:0] n_ofs;
    in_valid = v; in_addr = a; out_ready = rdy;
    cfg_range = rg; cfg_base = bs; cfg_pgsz = pg;
    #0.5;
    check("R2 in_ready", 32'(in_ready), 32'(!m_valid || rdy));
    acc = v && (!m_valid || rdy);
    r = (rg > 4'd8) ? 8 : int'(rg);
    p = int'(pg);
    n_inh = (r < 8) && ((a >> (24 + r)) != (bs >> (24 + r)));
    n_ofs = a & ((32'd1 << (12 + p)) - 32'd1);
    n_vpn = (a >> (12 + p)) & ((32'd1 << (12 + r - p)) - 32'd1);
    @(posedge clk);
    @(negedge clk);
    if (!m_valid || rdy) begin
      m_valid = acc;
      if (acc) begin
        m_inh = n_inh;
        m_vpn = n_inh ? 32'd0 : n_vpn;
        m_ofs = n_inh ? 32'd0 : n_ofs;
      end
    end
    check("R8/R2 out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      check("R3/R4 inhibit", 32'(out_inhibit), 32'(m_inh));
      check(m_inh ? "R7 vpn zero" : "R6 vpn", 32'(out_vpn), m_vpn);
      check(m_inh ? "R7 offset zero" : "R5 offset", 32'(out_offset), m_ofs);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);
    // R3: r=2, window at 0x0C000000, 64 MiB
    step(1, 32'h0C12_3456, 1, 4'd2, 32'h0C00_0000, 2'd0);
    step(1, 32'h0FFF_FFFF, 1, 4'd2, 32'h0C00_0000, 2'd0); // top window bit
    step(1, 32'h0800_0000, 1, 4'd2, 32'h0C00_0000, 2'd0); // lowest compared bit differs
    step(1, 32'h1C00_0000, 1, 4'd2, 32'h0C00_0000, 2'd0);
    // R3: r=0 boundary
    step(1, 32'h0100_0000, 1, 4'd0, 32'h0000_0000, 2'd0);
    step(1, 32'h00FF_FFFF, 1, 4'd0, 32'h0000_0000, 2'd3);
    // R4: r=8 and clamped values never inhibit
    step(1, 32'hDEAD_BEEF, 1, 4'd8, 32'h0000_0000, 2'd0);
    step(1, 32'hDEAD_BEEF, 1, 4'd12, 32'h1234_5678, 2'd1);
    step(1, 32'hFFFF_FFFF, 1, 4'd15, 32'h0000_0000, 2'd3);
    // R5/R6: each page size at both range extremes
    for (int pg = 0; pg < 4; pg++) begin
      step(1, 32'hA5A5_5A5A, 1, 4'd8, 32'h0, 2'(pg));
      step(1, 32'h00F7_ABCD, 1, 4'd0, 32'h0, 2'(pg));
    end
    // R2: stall holds output and drops in_ready
    step(1, 32'h1234_5678, 0, 4'd8, 32'h0, 2'd2);
    step(1, 32'h8765_4321, 0, 4'd8, 32'h0, 2'd0);
    step(0, 32'h0, 0, 4'd8, 32'h0, 2'd0);
    step(0, 32'h0, 1, 4'd8, 32'h0, 2'd0);
    // Random traffic with back-pressure and changing configuration
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 1) == 1) b = a ^ (32'd1 << $urandom_range(20, 31));
      step(bit'($urandom_range(0, 3) != 0), a, bit'($urandom_range(0, 2) != 0),
           4'($urandom_range(0, 15)), b, 2'($urandom_range(0, 3)));
    end
    summary();
  end
endmodule